// File: doc/BRIEF.md
# Serial-Load Trivium Keystream Generator

This block is a one-bit-per-clock Trivium stream-cipher engine. Its whole 288-bit state lives in one register split into three shift segments. The 80-bit key and the 80-bit IV come in one bit per clock on two serial pins, so the block needs few input wires. During loading, the heads of two segments take the incoming bits in place of the cipher feedback. The third segment keeps its reset value.

Once the last bit is in, a start pulse begins the warm-up. For 1152 clocks the state advances with `busy` high, and nothing leaves the block. The block then raises `ks_valid` and puts out one keystream bit on every clock. That continues until the next load or reset. A load strobe that arrives during warm-up or streaming ends the current session at once. The state returns to its reset value, and the strobed bits become the first bits of a new load.

Top module: `trv_keystream`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block clears the state, except state bits 286, 287 and 288, which it sets to 1. After that edge `ks_valid`, `busy` and `ks_bit` are all 0.
- R2: Each rising edge with `load` high shifts in one pair of bits. `key_bit` enters at state bit 1 and `iv_bit` enters at state bit 94. Within bits 1..93 and within bits 94..177, every other bit takes the value of the bit one index below it. Bits 178..288 hold. After 80 strobes, the n-th key bit presented sits at bit 81-n and the n-th IV bit presented sits at bit 174-n. The block then waits, loaded.
- R3: A `start` pulse in the loaded state raises `busy` on the next cycle. `busy` stays high for exactly 1152 cycles, and `ks_valid` stays low throughout.
- R4: The cipher taps are: t1 = s66^s93, t2 = s162^s177, t3 = s243^s288, and z = t1^t2^t3. On each update, bit 1 takes t3^(s286&s287)^s69, bit 94 takes t1^(s91&s92)^s171, and bit 178 takes t2^(s175&s176)^s264. Every other bit takes the value of its lower neighbour. The first cycle with `ks_valid` high shows z of the state after the 1152 warm-up updates, and each later cycle shows z of the next update.
- R5: `ks_valid` rises on the cycle after `busy` falls and then stays high until a load strobe or reset.
- R6: `ks_bit` is 0 on every cycle with `ks_valid` low.
- R7: `start` has no effect before all 80 bits are loaded, during warm-up, or during streaming. In particular, a `start` during warm-up does not lengthen it.
- R8: A cycle with `load` low during loading pauses the load without changing the state or the bit count.
- R9: A `load` strobe in the loaded, warm-up or streaming state restarts from the reset state of R1 and takes the strobed bits as the first of a new 80. On the next cycle `ks_valid` and `busy` are both 0.
- R10: A synchronous reset in the middle of streaming returns the block to R1. A following load-and-start session streams exactly as it would after power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| load | input | 1 | Qualifies one key/IV bit pair this cycle |
| key_bit | input | 1 | Serial key bit, highest index first |
| iv_bit | input | 1 | Serial IV bit, highest index first |
| start | input | 1 | Begins warm-up once loading has finished |
| ks_bit | output | 1 | Keystream bit, 0 when not valid |
| ks_valid | output | 1 | Keystream bit is valid this cycle |
| busy | output | 1 | Warm-up in progress |

## Verification
The hardest case to reach from the pins is a load strobe that cuts into a session in progress. The state must come back to its exact reset value, with the strobed bit landing on top of it. The only way to see this is the keystream of the next session, 1152 cycles later. The stimulus therefore aborts one session in the middle of warm-up and another in the middle of streaming. It inserts idle gaps and stray start pulses into the new load, and it compares every valid bit with an independent model of the cipher that loads the same bits at the positions given in R2.

// File: rtl/trv_pkg.sv
// Package: shared constants, tap positions and the phase type for the
// serial-load Trivium engine. The tap indices are zero-based: state bit sN
// of the cipher lives at vector index N-1.
package trv_pkg;
    localparam int STATE_W = 288;
    // zero-based heads of the three shift segments
    localparam int HEAD_A = 0;
    localparam int HEAD_B = 93;
    localparam int HEAD_C = 177;
    // output taps of each segment
    localparam int TAP_A_MID = 65;
    localparam int TAP_A_END = 92;
    localparam int TAP_B_MID = 161;
    localparam int TAP_B_END = 176;
    localparam int TAP_C_MID = 242;
    localparam int TAP_C_END = 287;
    // AND pairs and cross taps of the nonlinear feedback
    localparam int AND_A = 90;
    localparam int AND_B = 174;
    localparam int AND_C = 285;
    localparam int CROSS_A = 170;
    localparam int CROSS_B = 263;
    localparam int CROSS_C = 68;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LOAD,
        PH_READY,
        PH_WARM,
        PH_STREAM
    } phase_t;

    // Value the state takes on reset and on a session abort
    function automatic logic [STATE_W-1:0] reset_state();
        logic [STATE_W-1:0] v;
        v = '0;
        v[STATE_W-1 -: 3] = 3'b111;
        return v;
    endfunction
endpackage

// File: rtl/trv_state.sv
// Module: trv_state
// Holds the 288-bit cipher state and picks its next value: hold, a serial
// load shift (optionally starting from the reset value), or a cipher update.
// Assumes the controller never asserts shift_in and advance together.
module trv_state
    import trv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic shift_in,
    input  logic clear,
    input  logic advance,
    input  logic key_bit,
    input  logic iv_bit,
    output logic z
);
    logic [STATE_W-1:0] st;
    logic [STATE_W-1:0] base;
    logic [STATE_W-1:0] st_next;
    logic t1, t2, t3;
    logic n1, n2, n3;

    // Linear taps and the keystream bit
    always_comb begin
        t1 = st[TAP_A_MID] ^ st[TAP_A_END];
        t2 = st[TAP_B_MID] ^ st[TAP_B_END];
        t3 = st[TAP_C_MID] ^ st[TAP_C_END];
        z  = t1 ^ t2 ^ t3;
    end

    // Nonlinear feedback into the segment heads
    always_comb begin
        n1 = t1 ^ (st[AND_A] & st[AND_A+1]) ^ st[CROSS_A];
        n2 = t2 ^ (st[AND_B] & st[AND_B+1]) ^ st[CROSS_B];
        n3 = t3 ^ (st[AND_C] & st[AND_C+1]) ^ st[CROSS_C];
    end

    // Next-state selection between hold, serial load and cipher update
    always_comb begin
        base    = clear ? reset_state() : st;
        st_next = st;
        if (shift_in) begin
            st_next = {base[STATE_W-1:HEAD_C], base[HEAD_C-2:HEAD_B], iv_bit,
                       base[HEAD_B-2:HEAD_A], key_bit};
        end else if (advance) begin
            st_next = {st[STATE_W-2:HEAD_C], n2, st[HEAD_C-2:HEAD_B], n1,
                       st[HEAD_B-2:HEAD_A], n3};
        end
    end

    // State register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) st <= reset_state();
        else        st <= st_next;
    end
endmodule

// File: rtl/trv_ctrl.sv
// Module: trv_ctrl
// Session controller: counts the serial load bits, runs the warm-up rounds,
// and tells the state register when to clear, shift in or advance.
// A load strobe always wins over start.
module trv_ctrl
    import trv_pkg::*;
#(
    parameter int LOAD_BITS   = 80,
    parameter int WARM_ROUNDS = 1152
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load,
    input  logic   start,
    output phase_t phase,
    output logic   do_clear,
    output logic   do_advance
);
    localparam int LDW = $clog2(LOAD_BITS);
    localparam int WRW = $clog2(WARM_ROUNDS);
    localparam logic [LDW-1:0] LD_LAST = LDW'(LOAD_BITS - 1);
    localparam logic [WRW-1:0] WR_LAST = WRW'(WARM_ROUNDS - 1);

    logic [LDW-1:0] ld_cnt;
    logic [WRW-1:0] wr_cnt;

    // A strobe outside an ongoing load restarts from the reset state
    assign do_clear   = load && (phase == PH_READY || phase == PH_WARM ||
                                 phase == PH_STREAM);
    // The cipher advances during warm-up and streaming unless a load aborts
    assign do_advance = !load && (phase == PH_WARM || phase == PH_STREAM);

    // Phase sequencing together with the load and warm-up counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            ld_cnt <= '0;
            wr_cnt <= '0;
        end else if (load) begin
            wr_cnt <= '0;
            if (phase == PH_LOAD) begin
                if (ld_cnt == LD_LAST) begin
                    phase  <= PH_READY;
                    ld_cnt <= '0;
                end else begin
                    ld_cnt <= ld_cnt + 1'b1;
                end
            end else begin
                phase  <= PH_LOAD;
                ld_cnt <= LDW'(1);
            end
        end else begin
            case (phase)
                PH_READY: if (start) begin
                    phase  <= PH_WARM;
                    wr_cnt <= '0;
                end
                PH_WARM: begin
                    if (wr_cnt == WR_LAST) phase <= PH_STREAM;
                    else                   wr_cnt <= wr_cnt + 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/trv_keystream.sv
// Module: trv_keystream (top)
// Trivium keystream generator whose key and IV are loaded serially, followed
// by a silent warm-up and then one keystream bit per clock.
// Assumes key and IV bits arrive highest index first, one pair per load cycle.
module trv_keystream
    import trv_pkg::*;
#(
    parameter int LOAD_BITS   = 80,
    parameter int WARM_ROUNDS = 1152
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic key_bit,
    input  logic iv_bit,
    input  logic start,
    output logic ks_bit,
    output logic ks_valid,
    output logic busy
);
    phase_t phase;
    logic   do_clear;
    logic   do_advance;
    logic   z;

    trv_ctrl #(
        .LOAD_BITS  (LOAD_BITS),
        .WARM_ROUNDS(WARM_ROUNDS)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .start     (start),
        .phase     (phase),
        .do_clear  (do_clear),
        .do_advance(do_advance)
    );

    trv_state u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_in(load),
        .clear   (do_clear),
        .advance (do_advance),
        .key_bit (key_bit),
        .iv_bit  (iv_bit),
        .z       (z)
    );

    // Output flags follow the phase; the keystream is gated when not valid
    always_comb begin
        ks_valid = (phase == PH_STREAM);
        busy     = (phase == PH_WARM);
        ks_bit   = ks_valid & z;
    end
endmodule

// File: rtl/trv_keystream_chk.sv
// Module: trv_keystream_chk
// Port-level protocol checks for trv_keystream, attached with bind below.
// Measures warm-up length with its own counter rather than a deep $past.
module trv_keystream_chk #(
    parameter int WARM_ROUNDS = 1152
) (
    input logic clk,
    input logic rst_n,
    input logic load,
    input logic start,
    input logic ks_bit,
    input logic ks_valid,
    input logic busy
);
    localparam int RW = $clog2(WARM_ROUNDS) + 2;
    logic [RW-1:0] busy_run;

    // Counts consecutive cycles with busy high
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_run <= '0;
        else if (busy) busy_run <= busy_run + 1'b1;
        else           busy_run <= '0;
    end

    p_flags_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(ks_valid && busy));

    p_warm_length_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && $past(rst_n) && !$past(load)) |-> (busy_run == RW'(WARM_ROUNDS)));

    p_valid_after_warm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ks_valid) |-> $past(busy));

    p_valid_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ks_valid && !load) |=> ks_valid);

    p_bit_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ks_valid |-> !ks_bit);

    p_busy_needs_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    p_abort_drops_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (!ks_valid && !busy));
endmodule

bind trv_keystream trv_keystream_chk #(.WARM_ROUNDS(WARM_ROUNDS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .start   (start),
    .ks_bit  (ks_bit),
    .ks_valid(ks_valid),
    .busy    (busy)
);

// File: tb/trv_keystream_test.sv
// Scoreboard bench: a reference cipher model pushes expected keystream bits
// into a queue, and a monitor pops them on every valid output cycle.
module trv_keystream_test;
    localparam int WARM = 1152;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load = 1'b0;
    logic key_bit = 1'b0;
    logic iv_bit = 1'b0;
    logic start = 1'b0;
    logic ks_bit;
    logic ks_valid;
    logic busy;

    int checks = 0;
    int failures = 0;
    bit exp_q[$];
    bit [288:1] ref_s;

    always #4 clk = ~clk;

    trv_keystream uut (
        .clk(clk), .rst_n(rst_n), .load(load), .key_bit(key_bit),
        .iv_bit(iv_bit), .start(start), .ks_bit(ks_bit),
        .ks_valid(ks_valid), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference model, one-based indexing as in the requirements
    task automatic ref_reset();
        ref_s = '0;
        ref_s[286] = 1'b1; ref_s[287] = 1'b1; ref_s[288] = 1'b1;
    endtask

    task automatic ref_load(input bit k, input bit v);
        for (int i = 93; i >= 2; i--) ref_s[i] = ref_s[i-1];
        ref_s[1] = k;
        for (int i = 177; i >= 95; i--) ref_s[i] = ref_s[i-1];
        ref_s[94] = v;
    endtask

    task automatic ref_step(output bit zo);
        bit a, b, c;
        a = ref_s[66] ^ ref_s[93];
        b = ref_s[162] ^ ref_s[177];
        c = ref_s[243] ^ ref_s[288];
        zo = a ^ b ^ c;
        a = a ^ (ref_s[91] & ref_s[92]) ^ ref_s[171];
        b = b ^ (ref_s[175] & ref_s[176]) ^ ref_s[264];
        c = c ^ (ref_s[286] & ref_s[287]) ^ ref_s[69];
        ref_s = {ref_s[287:1], 1'b0};
        ref_s[1] = c;
        ref_s[94] = a;
        ref_s[178] = b;
    endtask

    // Monitor: compare valid bits with the queue, quiet bits otherwise
    always @(negedge clk) begin
        if (rst_n) begin
            if (ks_valid && exp_q.size() > 0) begin
                bit e;
                e = exp_q.pop_front();
                chk(ks_bit == e, "R4 keystream bit", ks_bit, e);
            end
            if (!ks_valid) chk(ks_bit == 1'b0, "R6 bit quiet when invalid", ks_bit, 0);
        end
    end

    // Driver: present 80 bit pairs highest index first; optional idle gaps
    // carrying a stray start pulse
    task automatic load_session(input bit [80:1] k, input bit [80:1] v, input bit gaps);
        for (int n = 1; n <= 80; n++) begin
            @(negedge clk);
            if (n == 2) chk(!ks_valid && !busy, "R9 flags low after strobe", {ks_valid, busy}, 0);
            if (gaps && (n % 9 == 0)) begin
                load = 1'b0; start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                chk(busy == 1'b0, "R7 R8 start ignored in gap", busy, 0);
            end
            load = 1'b1; key_bit = k[81-n]; iv_bit = v[81-n];
            ref_load(k[81-n], v[81-n]);
        end
        @(negedge clk);
        load = 1'b0;
        chk(!busy && !ks_valid, "R2 loaded and waiting", {busy, ks_valid}, 0);
    endtask

    // Start warm-up, push expected bits, measure busy length
    task automatic run_warm(input int nbits, input int mid_start);
        int cnt;
        bit zz;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < WARM; i++) ref_step(zz);
        for (int i = 0; i < nbits; i++) begin
            ref_step(zz);
            exp_q.push_back(zz);
        end
        cnt = 0;
        while (busy && cnt < 3000) begin
            chk(!ks_valid, "R3 no valid during warm-up", ks_valid, 0);
            cnt++;
            start = (cnt == mid_start);
            @(negedge clk);
        end
        start = 1'b0;
        chk(cnt == WARM, "R3 R7 warm-up length", cnt, WARM);
        chk(ks_valid == 1'b1, "R5 valid after warm-up", ks_valid, 1);
    endtask

    task automatic drain();
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        ref_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!ks_valid && !busy && !ks_bit, "R1 reset outputs", {ks_valid, busy, ks_bit}, 0);

        // start with nothing loaded
        start = 1'b1; @(negedge clk); start = 1'b0; @(negedge clk);
        chk(busy == 1'b0, "R7 start ignored when unloaded", busy, 0);

        // Session 1: all-zero key and IV, stray start during warm-up
        load_session(80'h0, 80'h0, 1'b0);
        run_warm(64, 600);
        drain();
        repeat (20) @(negedge clk);
        chk(ks_valid == 1'b1, "R5 valid holds", ks_valid, 1);

        // Session 2: aborts streaming, gapped load, start during stream
        ref_reset();
        load_session(80'h0123456789ABCDEF0F1E, 80'hF00DCAFE5A5A3C3C9669, 1'b1);
        run_warm(64, 0);
        while (exp_q.size() > 32) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;
        chk(busy == 1'b0 && ks_valid == 1'b1, "R7 start ignored in stream", {busy, ks_valid}, 1);
        drain();

        // Session 3: aborted in the middle of warm-up
        ref_reset();
        load_session(80'hFFFFFFFFFFFFFFFFFFFF, 80'h13579BDF2468ACE01122, 1'b0);
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (300) @(negedge clk);
        chk(busy == 1'b1, "R3 busy mid warm-up", busy, 1);
        ref_reset();
        load_session(80'h8000000000000000000A, 80'h00000000000000000001, 1'b0);
        run_warm(48, 0);
        drain();

        // Reset during streaming, then a fresh session
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(!ks_valid && !busy && !ks_bit, "R10 R1 reset mid stream", {ks_valid, busy, ks_bit}, 0);
        ref_reset();
        load_session(80'hDEADBEEF0BADF00D1234, 80'h55AA55AA55AA55AA55AA, 1'b0);
        run_warm(32, 0);
        drain();

        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule